// File: doc/BRIEF.md
# Serial Command Front End with Chained Readback

This block is the serial receive and transmit stage of a small multi-channel settings controller. A host clocks a 16-bit command word into it over a four-wire SPI link while chip select is low. When chip select returns high, and only if exactly sixteen bits arrived, the word is split into a 4-bit operation code, a 4-bit target address and an 8-bit data byte. These fields are handed to a separate command executor together with a single-cycle valid strobe.

The serial output is meant for an open-drain pad. The block supplies a data bit and an output enable, and the pad pulls the line low only when the enable is high and the bit is 0. By default the output replays the bits that entered during the previous frame, so several such blocks can be chained with one select line. When the executor answers a readback operation, it loads an internal value into the low byte of the serial register between frames. The following frame then shifts that value out. All pins are brought into the system clock domain through synchronisers, and the link works with SPI modes 0 and 3.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset, `cmd_valid` and `spi_sdo_oe` are low and the serial register is all zeros, so the first frame after reset shifts out sixteen 0 bits.
- R2: A frame of exactly 16 bits, sent MSB first, yields one `cmd_valid` pulse of one clock after chip select rises. `cmd_op` is bits 15..12 of the word, `cmd_addr` is bits 11..8 and `cmd_data` is bits 7..0.
- R3: If chip select rises after any bit count other than 16 (fewer or more), no `cmd_valid` pulse is issued.
- R4: `spi_sdo_oe` is high during a frame and low whenever chip select has been high for a few clocks.
- R5: During a frame, the bit presented on `spi_sdo` before rising edge k (k counted from 0) is the serial register's bit 15-k as it stood when the frame began. This is the previous frame's word, MSB first.
- R6: The serial register always keeps the last 16 bits received, even after a short or long frame. After more than 16 bits, `spi_sdo` continues with the bits received earlier in the same frame.
- R7: A pulse on `rb_load` while chip select is high replaces the low 8 bits of the serial register with `rb_data`. The next frame shifts out the previous frame's upper byte followed by that value.
- R8: A pulse on `rb_load` while chip select is low has no effect. The next frame still shifts out the unmodified word.
- R9: Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) deliver the same decoded fields and the same output bit sequence.
- R10: `spi_sdo` changes only on a falling serial clock edge or on the falling edge of chip select, never while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host (asynchronous) |
| spi_cs_n | input | 1 | Active-low chip select (asynchronous) |
| spi_sdi | input | 1 | Serial data in, sampled on rising serial clock |
| spi_sdo | output | 1 | Serial data out bit for the open-drain pad |
| spi_sdo_oe | output | 1 | Output enable for the open-drain pad |
| rb_load | input | 1 | Executor loads readback data into the serial register |
| rb_data | input | 8 | Readback value |
| cmd_valid | output | 1 | One-cycle strobe for a complete frame |
| cmd_op | output | 4 | Operation code of the decoded frame |
| cmd_addr | output | 4 | Target address of the decoded frame |
| cmd_data | output | 8 | Data byte of the decoded frame |

## Verification
The hardest situation to reach from the ports is a readback value that arrives while a frame is already in progress. The stimulus pulses `rb_load` in the middle of a frame, while the serial clock is high and between sampling edges. It then checks the bits shifted out by the next frame. A second hard case is a serial register whose history mixes a partial frame with an overlong one. Short and long frames are sent back to back, and a behavioural 16-bit model predicts every output bit, with the two clock polarities alternating from frame to frame.

// File: rtl/spi_fe_pkg.sv
`timescale 1ns/1ps
package spi_fe_pkg;
    localparam int OP_W    = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic frame_t split_frame(input logic [FRAME_W-1:0] w);
        frame_t f;
        f.op   = w[FRAME_W-1 -: OP_W];
        f.addr = w[DATA_W +: ADDR_W];
        f.data = w[DATA_W-1:0];
        return f;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
        return (c == CNT_W'(CNT_MAX)) ? c : c + 1'b1;
    endfunction
endpackage

// File: rtl/spi_fe_sync.sv
`timescale 1ns/1ps
module spi_fe_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[b]}};
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_fe_edges.sv
`timescale 1ns/1ps
module spi_fe_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic cs_n_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_active
);
    logic sclk_q, cs_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_n_q <= cs_n_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_fall   = ~cs_n_s & cs_n_q;
    assign cs_rise   = cs_n_s & ~cs_n_q;
    assign cs_active = ~cs_n_s;
endmodule

// File: rtl/spi_fe_shifter.sv
`timescale 1ns/1ps
module spi_fe_shifter
    import spi_fe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_fall,
    input  logic               cs_active,
    input  logic               sdi_s,
    input  logic               rb_load,
    input  logic [DATA_W-1:0]  rb_data,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               sdo,
    output logic               sdo_oe
);
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            sdo_oe <= cs_active;
            if (cs_fall) begin
                bit_cnt <= '0;
                sdo     <= shreg[FRAME_W-1];
            end else if (cs_active && sclk_rise) begin
                shreg   <= {shreg[FRAME_W-2:0], sdi_s};
                bit_cnt <= sat_inc(bit_cnt);
            end else if (cs_active && sclk_fall) begin
                sdo <= shreg[FRAME_W-1];
            end
            if (!cs_active && rb_load) begin
                shreg[DATA_W-1:0] <= rb_data;
            end
        end
    end

    assign word = shreg;

    assert_oe_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!cs_active && $past(!cs_active)) |-> !sdo_oe);

    assert_rb_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (rb_load && cs_active && !sclk_rise && !cs_fall) |=> $stable(shreg));

    assert_sdo_edge_only_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(sclk_fall) && !$past(cs_fall)) |-> $stable(sdo));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/spi_fe_framer.sv
`timescale 1ns/1ps
module spi_fe_framer
    import spi_fe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_rise,
    input  logic [CNT_W-1:0]   bit_cnt,
    input  logic [FRAME_W-1:0] word,
    output frame_t             cmd,
    output logic               cmd_valid
);
    logic frame_ok;
    assign frame_ok = cs_rise && (bit_cnt == CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= frame_ok;
            if (frame_ok) cmd <= split_frame(word);
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_strobe_after_select_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(cs_rise));

    assert_fields_held_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_valid) && !cmd_valid |-> $stable(cmd));
endmodule

// File: rtl/spi_cmd_frontend.sv
`timescale 1ns/1ps
module spi_cmd_frontend
    import spi_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    input  logic              rb_load,
    input  logic [DATA_W-1:0] rb_data,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    logic [2:0] pins_s;
    logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_active;
    logic [FRAME_W-1:0] word;
    logic [CNT_W-1:0]   bit_cnt;
    frame_t             cmd;

    spi_fe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst),
        .d({spi_sdi, spi_cs_n, spi_sclk}),
        .q(pins_s)
    );

    spi_fe_edges u_edges (
        .clk(clk), .rst(rst),
        .sclk_s(pins_s[0]), .cs_n_s(pins_s[1]),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_active(cs_active)
    );

    spi_fe_shifter u_shift (
        .clk(clk), .rst(rst),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_active(cs_active),
        .sdi_s(pins_s[2]),
        .rb_load(rb_load), .rb_data(rb_data),
        .word(word), .bit_cnt(bit_cnt),
        .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
    );

    spi_fe_framer u_framer (
        .clk(clk), .rst(rst),
        .cs_rise(cs_rise), .bit_cnt(bit_cnt), .word(word),
        .cmd(cmd), .cmd_valid(cmd_valid)
    );

    assign cmd_op   = cmd.op;
    assign cmd_addr = cmd.addr;
    assign cmd_data = cmd.data;
endmodule

// File: tb/tb_spi_cmd_frontend.sv
`timescale 1ns/1ps
module tb_spi_cmd_frontend;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_oe;
    logic rb_load = 1'b0;
    logic [7:0] rb_data = '0;
    logic cmd_valid;
    logic [3:0] cmd_op, cmd_addr;
    logic [7:0] cmd_data;

    always #2 clk = ~clk;

    spi_cmd_frontend dut (
        .clk(clk), .rst(rst),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi),
        .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .rb_load(rb_load), .rb_data(rb_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] m = '0;          // model of the serial register
    int strobes = 0;
    logic [15:0] cap = '0;
    bit prev_valid = 0;
    int cs_hi = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock reference checks
    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin
                strobes++;
                cap = {cmd_op, cmd_addr, cmd_data};
            end
            if (cmd_valid && prev_valid) chk(0, "R2 pulse width", 2, 1);
            prev_valid = cmd_valid;
            cs_hi = spi_cs_n ? cs_hi + 1 : 0;
            if (cs_hi >= 4) chk(spi_sdo_oe == 1'b0, "R4 idle enable", spi_sdo_oe, 0);
        end
    end

    task automatic send(input int nbits, input logic [31:0] w, input bit mode3,
                        input string req, input bit rb_mid, input logic [7:0] rb_val);
        logic b;
        logic expb;
        strobes = 0;
        spi_sclk = mode3;
        wclk(H);
        spi_cs_n = 1'b0;
        wclk(H);
        for (int i = 0; i < nbits; i++) begin
            b = w[nbits-1-i];
            if (mode3) spi_sclk = 1'b0;
            spi_sdi = b;
            wclk(H);
            expb = m[15];
            chk(spi_sdo == expb, mode3 ? {req, " R9 mode3"} : req, spi_sdo, expb);
            if (i == 0) chk(spi_sdo_oe == 1'b1, "R4 active enable", spi_sdo_oe, 1);
            spi_sclk = 1'b1;
            m = {m[14:0], b};
            if (rb_mid && i == 8) begin
                rb_data = rb_val; rb_load = 1'b1;
                wclk(1);
                rb_load = 1'b0;
                wclk(H - 1);
            end else begin
                wclk(H);
            end
            if (!mode3) begin
                chk(spi_sdo == expb, "R10 stable while clock high", spi_sdo, expb);
                spi_sclk = 1'b0;
            end
        end
        wclk(H);
        spi_cs_n = 1'b1;
        wclk(8);
        if (nbits == 16) begin
            chk(strobes == 1, "R2 strobe count", strobes, 1);
            chk(cap == w[15:0], mode3 ? "R2 R9 fields" : "R2 fields", cap, w[15:0]);
        end else begin
            chk(strobes == 0, "R3 no strobe on bad count", strobes, 0);
        end
        chk(spi_sdo_oe == 1'b0, "R4 released", spi_sdo_oe, 0);
    endtask

    task automatic readback(input logic [7:0] v);
        wclk(2);
        rb_data = v; rb_load = 1'b1;
        wclk(1);
        rb_load = 1'b0;
        m[7:0] = v;
        wclk(2);
    endtask

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(3);
        chk(cmd_valid == 1'b0, "R1 reset strobe", cmd_valid, 0);
        chk(spi_sdo_oe == 1'b0, "R1 reset enable", spi_sdo_oe, 0);

        send(16, 32'h3A5C, 0, "R1 zero history", 0, 8'h00);
        send(16, 32'h7F01, 1, "R5 echo", 0, 8'h00);
        send(16, 32'hE6B2, 0, "R5 echo", 0, 8'h00);
        send(12, 32'h0ABC, 1, "R5 echo short", 0, 8'h00);
        send(20, 32'h12345, 0, "R6 history long", 0, 8'h00);
        send(16, 32'h9200, 1, "R6 history after long", 0, 8'h00);
        readback(8'hC3);
        send(16, 32'h0000, 0, "R7 readback out", 0, 8'h00);
        readback(8'h5A);
        send(16, 32'h4411, 1, "R7 readback out mode3", 0, 8'h00);
        send(16, 32'h5511, 0, "R5 echo", 1, 8'hEE);
        send(16, 32'hFFFF, 1, "R8 mid-frame load ignored", 0, 8'h00);
        send(16, 32'h8001, 0, "R5 echo ones", 0, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule